// File: doc/BRIEF.md
# Prescaled PWM Channel with Boundary-Committed Settings

This block produces one pulse-width-modulated pin. A power-of-two prescaler slows the input clock. A 16-bit counter then steps through each period at the slowed rate. Each period has two phases. A window taken from a timing word selects the phase, and each phase drives the pin to its own programmed level. The block also emits a one-cycle marker each time a new period starts.

Software gives the block two 32-bit words through two write strobes. The timing word holds the window bounds. The period word holds the length, the two drive codes and the prescaler select. Written values first land in a pending set of registers. They move into the working set only when a period begins, so a period already in progress is never cut short or reshaped. The enable input starts and stops the channel.

Top module: `spwm_channel`

## Requirements
- R1: During reset and while the channel has not been enabled, `pwm_o` and `prd_start_o` are both 0.
- R2: Bits [15:0] of the period word set the period length P in prescaled ticks, and a value of 0 means P = 65536. The counter runs 0, 1, ..., P-1 and then returns to 0.
- R3: Bits [22:20] of the period word select the prescaler. Codes 0 to 7 make one counter step every 1, 2, 4, 8, 16, 64, 256 and 1024 clocks respectively.
- R4: The pin is in its busy phase while the count is at least timing-word bits [15:0] and below timing-word bits [31:16]. At every other count it is in its idle phase.
- R5: Period-word bits [17:16] give the drive code for the busy phase, and bits [19:18] give the code for the idle phase. Code 3 drives the pin high. Codes 2, 1 and 0 drive it low.
- R6: `prd_start_o` is 1 for exactly the clock cycles in which the counter sits at 0 as the first step of a period, including the first period after enabling.
- R7: The first clock edge that samples `en_i` high copies both pending words into the working set at once. In the cycle after that edge the count is 0 and `prd_start_o` is 1.
- R8: While the channel runs, written words take effect only at the first period start after a period-word write. A timing-word write with no period-word write after it changes nothing at later period starts.
- R9: A period-word write captured on the same clock edge as a period start does not commit at that start. The old settings run one more full period, and the new ones begin at the start after it.
- R10: The first clock edge that samples `en_i` low forces the pin low and clears the counter and the prescaler. Writes made while the channel is disabled leave the pin low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Channel enable |
| act_we_i | input | 1 | Write strobe for the timing word |
| act_wdata_i | input | 32 | Timing word: window start [15:0], window end [31:16] |
| per_we_i | input | 1 | Write strobe for the period word |
| per_wdata_i | input | 32 | Period word: length [15:0], busy code [17:16], idle code [19:18], prescale select [22:20] |
| pwm_o | output | 1 | Modulated output pin |
| prd_start_o | output | 1 | One-cycle period-start marker |

## Verification
The period-word write and the period-boundary commit can land on the same clock edge. The bench provokes this by timing a period-word write so that its strobe is captured on the exact edge where the counter wraps, with no earlier write left waiting. The scoreboard then expects the old waveform for one more whole period and the new waveform from the following start. A design that commits the colliding write early, or drops it, shows up as a pin mismatch in one of those two periods.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned PRE_W   = 10;
  localparam int unsigned SHIFT_W = $clog2(PRE_W + 1);

  localparam logic [1:0] DRV_HIGH = 2'b11;

  typedef struct packed {
    logic [WORD_W-CNT_W-SEL_W-5:0] spare;
    logic [SEL_W-1:0]              div_sel;
    logic [1:0]                    idle_drv;
    logic [1:0]                    busy_drv;
    logic [CNT_W-1:0]              len;
  } per_word_t;

  typedef struct packed {
    logic [CNT_W-1:0] stop;
    logic [CNT_W-1:0] start;
  } act_word_t;

  // Non-linear prescale table: select code to log2 of the divide ratio.
  function automatic logic [SHIFT_W-1:0] div_shift(input logic [SEL_W-1:0] sel);
    logic [SHIFT_W-1:0] sh;
    case (sel)
      3'd5:    sh = SHIFT_W'(6);
      3'd6:    sh = SHIFT_W'(8);
      3'd7:    sh = SHIFT_W'(10);
      default: sh = SHIFT_W'(sel);
    endcase
    return sh;
  endfunction

endpackage

// File: rtl/spwm_prescaler.sv
module spwm_prescaler
  import spwm_pkg::*;
#(
  parameter int unsigned DIV_W = PRE_W,
  parameter int unsigned SH_W  = SHIFT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic [SH_W-1:0] shift_i,
  output logic            tick_o
);

  logic [DIV_W-1:0] pre_q, pre_d, limit;

  always_comb begin
    limit  = ~({DIV_W{1'b1}} << shift_i);
    tick_o = run_i && (pre_q == limit);
    if (!run_i || tick_o) pre_d = '0;
    else                  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

endmodule

// File: rtl/spwm_counter.sv
module spwm_counter
  import spwm_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic [W-1:0] len_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q, cnt_d, last;

  always_comb begin
    last   = len_i - 1'b1;  // a length of 0 yields all ones: full 2^W range
    wrap_o = tick_i && (cnt_q == last);
    cnt_d  = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/spwm_shadow.sv
module spwm_shadow
  import spwm_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_we_i,
  input  logic [W-1:0] act_wdata_i,
  input  logic         per_we_i,
  input  logic [W-1:0] per_wdata_i,
  input  logic         load_i,
  input  logic         bound_i,
  output logic [W-1:0] act_live_o,
  output logic [W-1:0] per_live_o
);

  logic [W-1:0] act_pend_q, act_pend_d, per_pend_q, per_pend_d;
  logic [W-1:0] act_live_q, act_live_d, per_live_q, per_live_d;
  logic         armed_q, armed_d, commit;

  always_comb begin
    act_pend_d = act_pend_q;
    per_pend_d = per_pend_q;
    act_live_d = act_live_q;
    per_live_d = per_live_q;
    commit     = load_i || (bound_i && armed_q);
    if (act_we_i) act_pend_d = act_wdata_i;
    if (per_we_i) per_pend_d = per_wdata_i;
    if (commit) begin
      act_live_d = act_pend_q;
      per_live_d = per_pend_q;
    end
    if (per_we_i)    armed_d = 1'b1;
    else if (commit) armed_d = 1'b0;
    else             armed_d = armed_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pend_q <= '0;
      per_pend_q <= '0;
      act_live_q <= '0;
      per_live_q <= '0;
      armed_q    <= 1'b0;
    end else begin
      act_pend_q <= act_pend_d;
      per_pend_q <= per_pend_d;
      act_live_q <= act_live_d;
      per_live_q <= per_live_d;
      armed_q    <= armed_d;
    end
  end

  assign act_live_o = act_live_q;
  assign per_live_o = per_live_q;

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel
  import spwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              act_we_i,
  input  logic [WORD_W-1:0] act_wdata_i,
  input  logic              per_we_i,
  input  logic [WORD_W-1:0] per_wdata_i,
  output logic              pwm_o,
  output logic              prd_start_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              en_q, prd_q, prd_d;
  logic              start, run, tick, wrap, busy;
  logic [1:0]        drv;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] act_live_w, per_live_w;
  per_word_t         per_live;
  act_word_t         act_live;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign start = en_i && !en_q;
  assign run   = en_i && en_q;

  spwm_shadow #(.W(WORD_W)) u_shadow (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .act_we_i    (act_we_i),
    .act_wdata_i (act_wdata_i),
    .per_we_i    (per_we_i),
    .per_wdata_i (per_wdata_i),
    .load_i      (start),
    .bound_i     (wrap),
    .act_live_o  (act_live_w),
    .per_live_o  (per_live_w)
  );

  assign per_live = per_word_t'(per_live_w);
  assign act_live = act_word_t'(act_live_w);

  spwm_prescaler #(.DIV_W(PRE_W), .SH_W(SHIFT_W)) u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .run_i   (run),
    .shift_i (div_shift(per_live.div_sel)),
    .tick_o  (tick)
  );

  spwm_counter #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run),
    .tick_i (tick),
    .len_i  (per_live.len),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  always_comb begin
    busy  = (cnt >= act_live.start) && (cnt < act_live.stop);
    drv   = busy ? per_live.busy_drv : per_live.idle_drv;
    pwm_o = en_q && (drv == DRV_HIGH);
    prd_d = start || wrap;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      prd_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      prd_q <= prd_d;
    end
  end

  assign prd_start_o = prd_q;

endmodule

// File: rtl/spwm_channel_chk.sv
module spwm_channel_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        en_q_i,
  input logic        pwm_i,
  input logic        start_i,
  input logic [15:0] cnt_i,
  input logic [31:0] per_live_i
);

  // R10: a disable sampled on the previous edge leaves the pin low and the count cleared
  a_r10_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) |-> (!pwm_i && cnt_i == 16'd0));

  // R6: the start marker only appears with the count at zero on a running channel
  a_r6_start_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (cnt_i == 16'd0 && en_q_i));

  // R2: the count stays below a non-zero period length
  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q_i && per_live_i[15:0] != 16'd0) |-> (cnt_i < per_live_i[15:0]));

  // R2: the count only ever steps by one or returns to zero
  a_r2_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($changed(cnt_i) && cnt_i != 16'd0) |-> (cnt_i == $past(cnt_i) + 16'd1));

  // R8: working settings change only together with a period start
  a_r8_commit_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(per_live_i) |-> start_i);

endmodule

bind spwm_channel spwm_channel_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_n),
  .en_i       (en_i),
  .en_q_i     (en_q),
  .pwm_i      (pwm_o),
  .start_i    (prd_start_o),
  .cnt_i      (cnt),
  .per_live_i (per_live_w)
);

// File: tb/spwm_channel_bench.sv
`timescale 1ns/1ps
module spwm_channel_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        act_we_i = 1'b0;
  logic [31:0] act_wdata_i = '0;
  logic        per_we_i = 1'b0;
  logic [31:0] per_wdata_i = '0;
  logic        pwm_o, prd_start_o;

  typedef struct {
    int unsigned cyc;
    bit          is_start;
    bit          val;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  int unsigned cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  spwm_channel u_spwm_channel (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .act_we_i    (act_we_i),
    .act_wdata_i (act_wdata_i),
    .per_we_i    (per_we_i),
    .per_wdata_i (per_wdata_i),
    .pwm_o       (pwm_o),
    .prd_start_o (prd_start_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit actual, bit expv, string tag, string what);
    checks++;
    if (actual !== expv) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cyc, actual, expv);
    end
  endtask

  // Monitor: compare outputs against queued expectations at each falling edge.
  always @(negedge clk) begin
    exp_t e;
    while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
      e = sb_q.pop_front();
      if (e.cyc < cyc) begin
        checks++;
        errors++;
        $display("FAIL %s stale expectation: actual cycle %0d expected cycle %0d", e.tag, cyc, e.cyc);
      end else if (e.is_start) check(prd_start_o, e.val, e.tag, "prd_start_o");
      else                     check(pwm_o, e.val, e.tag, "pwm_o");
    end
  end

  // Reference values derived from the requirements.
  function automatic int unsigned tb_shift(logic [2:0] sel);
    case (sel)
      3'd5: return 6;
      3'd6: return 8;
      3'd7: return 10;
      default: return int'(sel);
    endcase
  endfunction

  function automatic int unsigned tb_len(logic [31:0] p);
    return (p[15:0] == 16'd0) ? 65536 : int'(p[15:0]);
  endfunction

  function automatic bit fn_pin(logic [31:0] a, logic [31:0] p, int unsigned t);
    int unsigned c    = (t >> tb_shift(p[22:20])) % tb_len(p);
    bit          busy = (c >= a[15:0]) && (c < a[31:16]);
    logic [1:0]  code = busy ? p[17:16] : p[19:18];
    return code == 2'b11;
  endfunction

  function automatic bit fn_start(logic [31:0] p, int unsigned t);
    return (t % (tb_len(p) << tb_shift(p[22:20]))) == 0;
  endfunction

  function automatic logic [31:0] mk_per(int unsigned sel, int unsigned idle, int unsigned busy, int unsigned len);
    return (32'(sel) << 20) | (32'(idle) << 18) | (32'(busy) << 16) | 32'(len & 16'hFFFF);
  endfunction

  // Driver side: push expectations and drive stimulus.
  task automatic push(int unsigned c, bit st, bit v, string tag);
    exp_t e;
    e.cyc = c; e.is_start = st; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic push_span(int unsigned b, int unsigned t0, int unsigned n,
                           logic [31:0] a, logic [31:0] p, string tp, string ts);
    for (int unsigned k = t0; k < t0 + n; k++) begin
      push(b + k, 1'b0, fn_pin(a, p, k), tp);
      push(b + k, 1'b1, fn_start(p, k), ts);
    end
  endtask

  task automatic push_zero(int unsigned c0, int unsigned n, string tag);
    for (int unsigned k = 0; k < n; k++) begin
      push(c0 + k, 1'b0, 1'b0, tag);
      push(c0 + k, 1'b1, 1'b0, tag);
    end
  endtask

  task automatic wait_to(int unsigned c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic write_act(logic [31:0] v);
    act_we_i = 1'b1; act_wdata_i = v;
    @(negedge clk);
    act_we_i = 1'b0;
  endtask

  task automatic write_per(logic [31:0] v);
    per_we_i = 1'b1; per_wdata_i = v;
    @(negedge clk);
    per_we_i = 1'b0;
  endtask

  // Load both words while disabled, enable, run n cycles, disable again.
  task automatic fresh_run(logic [31:0] a, logic [31:0] p, int unsigned n, string tp, string ts);
    int unsigned b;
    write_act(a);
    write_per(p);
    b = cyc + 1;
    push_span(b, 0, n, a, p, tp, ts);
    en_i = 1'b1;
    wait_to(b + n - 1);
    en_i = 1'b0;
    push_zero(b + n, 2, "R10");
    wait_to(b + n + 1);
  endtask

  initial begin : main
    int unsigned b, nb, nc, bd;
    logic [31:0] a_a, p_a, a_b, p_b, a_c, p_c, a_d, p_d, a_e, p_e, a_f, a_g, p_g;
    int unsigned pts[5];

    a_a = {16'd3, 16'd1};  p_a = mk_per(0, 2, 3, 5);
    a_b = {16'd6, 16'd0};  p_b = mk_per(1, 3, 2, 8);
    a_c = {16'd2, 16'd1};  p_c = mk_per(2, 2, 3, 4);
    a_d = {16'd2, 16'd0};  p_d = mk_per(0, 3, 1, 3);
    a_e = {16'd1, 16'd0};  p_e = mk_per(0, 0, 3, 2);
    a_f = {16'd1, 16'd0};
    a_g = {16'h8000, 16'd0}; p_g = mk_per(0, 2, 3, 0);

    // R1: reset state
    repeat (4) @(negedge clk);
    check(pwm_o, 1'b0, "R1", "pwm_o in reset");
    check(prd_start_o, 1'b0, "R1", "prd_start_o in reset");
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    push_zero(cyc + 1, 3, "R1");
    wait_to(cyc + 3);

    // R4/R7: first run; R8: running updates; R9: write colliding with a boundary
    write_act(a_a);
    write_per(p_a);
    b  = cyc + 1;
    nb = b + 30;
    nc = nb + 48;
    push_span(b,  0,  30, a_a, p_a, "R4", "R7");
    push_span(nb, 0,  32, a_b, p_b, "R8", "R6");
    push_span(nb, 32, 16, a_b, p_b, "R9", "R9");
    push_span(nc, 0,  32, a_c, p_c, "R9", "R6");
    en_i = 1'b1;
    wait_to(b + 21);  write_act(a_b);   // timing word alone: must not commit at t=25
    wait_to(b + 27);  write_per(p_b);   // arms commit at t=30
    wait_to(nb + 20); write_act(a_c);   // no arm
    wait_to(nb + 31); write_per(p_c);   // captured on the boundary edge nb+32
    wait_to(nc + 31);
    en_i = 1'b0;
    push_zero(nc + 32, 3, "R10");
    wait_to(nc + 32);

    // R5: drive codes 1 and 0 are low; R8: commit while running
    write_act(a_d);
    write_per(p_d);
    bd = cyc + 1;
    push_span(bd,      0, 15, a_d, p_d, "R5", "R6");
    push_span(bd + 15, 0, 10, a_e, p_e, "R5", "R8");
    en_i = 1'b1;
    wait_to(bd + 12); write_act(a_e);
    write_per(p_e);
    wait_to(bd + 24);
    en_i = 1'b0;
    push_zero(bd + 25, 2, "R10");
    wait_to(bd + 26);

    // R3: every prescale select, two periods each
    for (int s = 0; s < 8; s++)
      fresh_run(a_f, mk_per(s, 2, 3, 2), 4 << tb_shift(3'(s)), "R3", "R3");

    // R2: length field 0 means 65536 ticks
    write_act(a_g);
    write_per(p_g);
    b = cyc + 1;
    pts = '{0, 32767, 32768, 65535, 65536};
    foreach (pts[i]) begin
      push(b + pts[i], 1'b0, fn_pin(a_g, p_g, pts[i]), "R2");
      push(b + pts[i], 1'b1, fn_start(p_g, pts[i]), "R2");
    end
    en_i = 1'b1;
    wait_to(b + 65536);
    en_i = 1'b0;
    push_zero(b + 65537, 2, "R10");
    wait_to(b + 65540);

    if (sb_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending items expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion earlier", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule